// File: doc/BRIEF.md
# Trigger Location and Ramp-Start Logic

This block marks where a trigger event landed inside a circular store of 32 sample slots. It also starts a set of interpolation ramps on staggered clock edges. A 5-bit position counter runs freely and steps once for each sample-advance strobe.

When the first trigger after arming arrives, the block latches two things into a location code:
- the low bits of the position count;
- the sampled level of the master-clock phase, which resolves the trigger to half a sample interval.

It then raises the first ramp-start pair on the next falling clock edge and the second pair on the rising edge after that. Each pair is a true/complement output.

A separate record-trigger strobe loads the full position count into a holding register. That strobe is forwarded as a one-cycle synchronous pulse, aligned to the next sample-advance strobe, so the downstream sequencer can start its post-trigger count on a sample boundary. All captured state holds until an arm strobe clears it.

Top module: `trig_locator`

## Requirements
- R1: While reset is low at a rising edge, the following are all cleared: the location code, the captured count, all ramp true outputs (complements high) and the synchronous trigger pulse.
- R2: The position counter is 5 bits wide. It adds one at each rising edge where `smp_adv` is high and wraps from 31 to 0. Its value is observed through `trig_cnt` and `trig_loc`.
- R3: On the accepted trigger, `trig_loc[4:1]` takes bits 3..0 of the position count as it stood before that edge, and `trig_loc[0]` takes the level of `clk_phase` (1 = phase-3 side, 0 = phase-1 side). The result is visible after that edge.
- R4: Only the first trigger after arm (or reset) is accepted. Later triggers, and a trigger that coincides with `arm`, leave `trig_loc` unchanged.
- R5: The first ramp pair (`ramp_p[0]` high, `ramp_n[0]` low) asserts on the falling edge that follows the rising edge accepting the trigger. It is still low before that falling edge.
- R6: The second ramp pair (`ramp_p[1]` high, `ramp_n[1]` low) asserts on the next rising edge, one cycle after the trigger was accepted. Both pairs stay asserted until arm.
- R7: The first `rec_trig` after arm loads the position count (value before that edge) into `trig_cnt`. Later strobes are ignored, and the value holds until arm.
- R8: `sync_trig` is a one-cycle pulse. It follows the first rising edge after the capture edge at which `smp_adv` is high. It occurs once per capture and never while no capture is pending.
- R9: `arm` at a rising edge clears the location code, the captured count, any pending synchronous pulse and the second ramp pair at that edge. It clears the first ramp pair at the falling edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Re-arm strobe, clears captured state |
| smp_adv | input | 1 | Sample-position advance strobe |
| trig_evt | input | 1 | Trigger event |
| clk_phase | input | 1 | Sampled master-clock phase level |
| rec_trig | input | 1 | Record-trigger strobe |
| trig_loc | output | 5 | Trigger location code {slot[3:0], phase} |
| trig_cnt | output | 5 | Position count captured by the record trigger |
| ramp_p | output | 2 | Ramp-start pairs, true side |
| ramp_n | output | 2 | Ramp-start pairs, complement side |
| sync_trig | output | 1 | Record trigger aligned to sample advance |

## Verification
The result timings differ by output:
- `trig_loc` and `trig_cnt` are due just after the rising edge that samples the strobe.
- The first ramp pair is due half a cycle later.
- The second ramp pair is due one full cycle later.
- `sync_trig` is due after the first later edge that also sees `smp_adv`.

The bench drives inputs 3 ns after a rising edge. It samples registered results 1 ns after the next rising edge, and samples the first ramp pair 1 ns after the falling edge, so every check lands on a settled value. For `sync_trig`, the driver stamps each expected pulse with the index of the edge that must produce it. The monitor compares that index against its own edge count, so an early, late, missing or stretched pulse is caught.

// File: rtl/tl_pkg.sv
// Shared definitions for the trigger location block.
// Assumes: ramp stages alternate edges, starting with a falling edge.
package tl_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    // Edge on which ramp stage idx updates: even stages fall, odd stages rise.
    function automatic edge_sel_e stage_edge(input int unsigned idx);
        return ((idx % 2) == 0) ? EDGE_FALL : EDGE_RISE;
    endfunction

endpackage

// File: rtl/tl_pos_counter.sv
// Free-running sample-position counter.
// Steps once per sample-advance strobe and wraps modulo 2**POS_W.
// Assumes: synchronous active-low reset; arm does not touch it.
module tl_pos_counter #(
    parameter int unsigned POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] STEP = 1;

    // Advance the slot index on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (adv) begin
            pos <= pos + STEP;
        end
    end

    // R2
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (pos == $past(pos) + STEP));

    // R2
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos));

endmodule

// File: rtl/tl_trig_capture.sv
// Latches the trigger location code on the first trigger after arm.
// Code = {slot bits, phase level}; hit flags that a trigger was taken.
// Assumes: arm has priority over a coincident trigger.
module tl_trig_capture #(
    parameter int unsigned POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig,
    input  logic             ph_lvl,
    input  logic [POS_W-2:0] pos_low,
    output logic [POS_W-1:0] loc,
    output logic             hit
);

    // Capture slot and half-interval phase once per arm.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            loc <= '0;
            hit <= 1'b0;
        end else if (trig && !hit) begin
            loc <= {pos_low, ph_lvl};
            hit <= 1'b1;
        end
    end

    // R4
    loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !arm) |=> ($stable(loc) && hit));

    // R9
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!hit && (loc == '0)));

endmodule

// File: rtl/tl_ramp_start.sv
// Staggered ramp-start chain.
// Stage 0 follows hit on the falling edge; each next stage follows
// the one before it on the opposite edge. Rising stages clear on arm,
// and falling stages drop one half-cycle later as their source falls.
// Assumes: NPAIR >= 2; hit is a level that holds until arm.
module tl_ramp_start #(
    parameter int unsigned NPAIR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             hit,
    output logic [NPAIR-1:0] stage
);

    import tl_pkg::*;

    logic [NPAIR-1:0] src;
    assign src = {stage[NPAIR-2:0], hit};

    for (genvar i = 0; i < NPAIR; i++) begin : g_stage
        logic q;
        assign stage[i] = q;

        if (stage_edge(i) == EDGE_FALL) begin : g_fall
            // Follow the source half a cycle later on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else begin
                    q <= src[i];
                end
            end

            // R5
            fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q |-> src[i]);
        end else begin : g_rise
            // Follow the source on the rising edge; arm clears it at once.
            always_ff @(posedge clk) begin
                if (!rst_n || arm) begin
                    q <= 1'b0;
                end else begin
                    q <= src[i];
                end
            end

            // R6
            rise_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q |-> src[i]);

            // R6
            rise_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (src[i] && !arm) |=> q);
        end
    end

endmodule

// File: rtl/tl_rec_sync.sv
// Record-trigger capture and resynchroniser.
// The first record strobe after arm loads the position count. A pending
// flag then waits for the next sample-advance strobe and issues a
// one-cycle synchronous pulse.
// Assumes: the capture edge itself never releases the pulse.
module tl_rec_sync #(
    parameter int unsigned POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rec,
    input  logic             adv,
    input  logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] cap,
    output logic             sync
);

    logic seen;
    logic pend;

    // Capture the count once and release the pulse on a sample boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            cap  <= '0;
            seen <= 1'b0;
            pend <= 1'b0;
            sync <= 1'b0;
        end else begin
            sync <= pend && adv;
            if (pend && adv) begin
                pend <= 1'b0;
            end
            if (rec && !seen) begin
                cap  <= pos;
                seen <= 1'b1;
                pend <= 1'b1;
            end
        end
    end

    // R8
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !sync);

    // R8
    sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !adv) |=> !sync);

    // R7
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !arm) |=> $stable(cap));

endmodule

// File: rtl/trig_locator.sv
// Trigger location and ramp-start logic, top level.
// Wires the position counter, the trigger capture, the staggered
// ramp chain and the record-trigger resynchroniser.
// Assumes: clk_phase is a level already sampled into the clk domain.
module trig_locator #(
    parameter int unsigned POS_W = 5,
    parameter int unsigned NPAIR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             smp_adv,
    input  logic             trig_evt,
    input  logic             clk_phase,
    input  logic             rec_trig,
    output logic [POS_W-1:0] trig_loc,
    output logic [POS_W-1:0] trig_cnt,
    output logic [NPAIR-1:0] ramp_p,
    output logic [NPAIR-1:0] ramp_n,
    output logic             sync_trig
);

    logic [POS_W-1:0] pos;
    logic             hit;
    logic [NPAIR-1:0] stage;

    tl_pos_counter #(.POS_W(POS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (smp_adv),
        .pos   (pos)
    );

    tl_trig_capture #(.POS_W(POS_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .trig    (trig_evt),
        .ph_lvl  (clk_phase),
        .pos_low (pos[POS_W-2:0]),
        .loc     (trig_loc),
        .hit     (hit)
    );

    tl_ramp_start #(.NPAIR(NPAIR)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .hit   (hit),
        .stage (stage)
    );

    tl_rec_sync #(.POS_W(POS_W)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .rec   (rec_trig),
        .adv   (smp_adv),
        .pos   (pos),
        .cap   (trig_cnt),
        .sync  (sync_trig)
    );

    // Drive each ramp pair as true and complement.
    assign ramp_p = stage;
    assign ramp_n = ~stage;

endmodule

// File: tb/trig_locator_tb.sv
module trig_locator_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, arm = 1'b0, smp_adv = 1'b0, trig_evt = 1'b0;
    logic clk_phase = 1'b0, rec_trig = 1'b0;
    logic [4:0] trig_loc, trig_cnt;
    logic [1:0] ramp_p, ramp_n;
    logic       sync_trig;

    trig_locator u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .smp_adv(smp_adv),
        .trig_evt(trig_evt), .clk_phase(clk_phase), .rec_trig(rec_trig),
        .trig_loc(trig_loc), .trig_cnt(trig_cnt), .ramp_p(ramp_p),
        .ramp_n(ramp_n), .sync_trig(sync_trig)
    );

    int total = 0;
    int bad   = 0;
    int ecnt  = 0;

    typedef struct {
        logic [4:0] cap;
        int         due;
    } item_t;
    item_t sbq[$];

    logic [4:0] cnt_m = '0;
    bit trig_seen_m = 0, rec_seen_m = 0, pend_m = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        smp_adv = 0; trig_evt = 0; clk_phase = 0; rec_trig = 0; arm = 0;
    endtask

    // Driver: applies one cycle of stimulus and pushes expected pulses.
    task automatic tick(input bit adv, input bit trg, input bit ph, input bit rec, input bit ar);
        item_t it;
        smp_adv = adv; trig_evt = trg; clk_phase = ph; rec_trig = rec; arm = ar;
        if (ar) begin
            trig_seen_m = 0; rec_seen_m = 0; pend_m = 0;
            sbq.delete();
        end else begin
            if (trg && !trig_seen_m) trig_seen_m = 1;
            if (pend_m && adv) begin
                it = sbq.pop_front();
                it.due = ecnt + 1;
                sbq.push_front(it);
                pend_m = 0;
            end
            if (rec && !rec_seen_m) begin
                it.cap = cnt_m;
                it.due = -1;
                sbq.push_back(it);
                rec_seen_m = 1;
                pend_m = 1;
            end
        end
        cnt_m = cnt_m + 5'(adv);
        @(posedge clk);
        #3;
    endtask

    // Monitor: pops expected sync pulses at their due edge (R8, R7).
    always begin
        @(posedge clk);
        ecnt++;
        #1;
        if (rst_n) begin
            if (sbq.size() > 0 && sbq[0].due == ecnt) begin
                chk("R8 sync pulse due", {31'd0, sync_trig}, 32'd1);
                chk("R7 count at sync", {27'd0, trig_cnt}, {27'd0, sbq[0].cap});
                void'(sbq.pop_front());
            end else if (sync_trig) begin
                chk("R8 unexpected sync", {31'd0, sync_trig}, 32'd0);
            end
        end
    end

    initial begin
        #1600000;
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #3;
        // R1 reset state
        chk("R1 loc", {27'd0, trig_loc}, 32'd0);
        chk("R1 cnt", {27'd0, trig_cnt}, 32'd0);
        chk("R1 ramp_p", {30'd0, ramp_p}, 32'd0);
        chk("R1 ramp_n", {30'd0, ramp_n}, 32'd3);
        chk("R1 sync", {31'd0, sync_trig}, 32'd0);
        rst_n = 1;

        // R2 advance to slot 7, R3 trigger with phase high
        repeat (7) tick(1, 0, 0, 0, 0);
        tick(0, 1, 1, 0, 0);
        idle();
        chk("R3 loc slot7 ph1", {27'd0, trig_loc}, 32'h0F);
        chk("R5 pair1 before fall", {31'd0, ramp_p[0]}, 32'd0);
        #2;
        chk("R5 pair1 true", {31'd0, ramp_p[0]}, 32'd1);
        chk("R5 pair1 comp", {31'd0, ramp_n[0]}, 32'd0);
        chk("R6 pair2 not yet", {31'd0, ramp_p[1]}, 32'd0);
        @(posedge clk);
        #3;
        chk("R6 pair2 true", {31'd0, ramp_p[1]}, 32'd1);
        chk("R6 pair2 comp", {31'd0, ramp_n[1]}, 32'd0);

        // R4 later trigger ignored
        repeat (3) tick(1, 0, 0, 0, 0);
        tick(0, 1, 0, 0, 0);
        chk("R4 loc held", {27'd0, trig_loc}, 32'h0F);
        chk("R6 pairs held", {30'd0, ramp_p}, 32'd3);

        // R7 record capture at slot 10, R8 waits for advance
        tick(0, 0, 0, 1, 0);
        chk("R7 cap slot10", {27'd0, trig_cnt}, 32'd10);
        repeat (3) tick(0, 0, 0, 0, 0);
        chk("R8 no sync without adv", {31'd0, sync_trig}, 32'd0);
        tick(1, 0, 0, 1, 0);
        repeat (2) tick(0, 0, 0, 0, 0);
        chk("R8 sync ended", {31'd0, sync_trig}, 32'd0);
        chk("R7 second rec ignored", {27'd0, trig_cnt}, 32'd10);

        // R9 arm clears state
        tick(0, 0, 0, 0, 1);
        idle();
        chk("R9 loc cleared", {27'd0, trig_loc}, 32'd0);
        chk("R9 cap cleared", {27'd0, trig_cnt}, 32'd0);
        chk("R9 pair2 cleared", {31'd0, ramp_p[1]}, 32'd0);
        chk("R9 pair1 still set", {31'd0, ramp_p[0]}, 32'd1);
        #2;
        chk("R9 pair1 cleared", {31'd0, ramp_p[0]}, 32'd0);
        @(posedge clk);
        #3;

        // R4 trigger coincident with arm ignored
        tick(0, 1, 1, 0, 1);
        chk("R4 trig with arm", {27'd0, trig_loc}, 32'd0);
        tick(0, 0, 0, 0, 0);
        chk("R4 no ramp after arm trig", {30'd0, ramp_p}, 32'd0);

        // R2 wrap: slot 11 + 25 = 36 -> 4
        repeat (25) tick(1, 0, 0, 0, 0);
        tick(0, 1, 0, 1, 0);
        chk("R2 wrap loc", {27'd0, trig_loc}, 32'h08);
        chk("R2 wrap cap", {27'd0, trig_cnt}, 32'd4);
        tick(1, 0, 0, 0, 0);
        repeat (3) tick(0, 0, 0, 0, 0);

        // R3/R7 slot 20: upper count bit lands in cap only
        tick(0, 0, 0, 0, 1);
        repeat (15) tick(1, 0, 0, 0, 0);
        tick(0, 1, 1, 1, 0);
        chk("R3 loc slot20 ph1", {27'd0, trig_loc}, 32'h09);
        chk("R7 cap slot20", {27'd0, trig_cnt}, 32'd20);
        tick(0, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0);
        repeat (3) tick(0, 0, 0, 0, 0);

        chk("R8 all pulses seen", sbq.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule